// File: doc/BRIEF.md
# Paged CAN Controller Window Decoder

This block sits between an 8-bit ISA-style host I/O bus and an external CAN controller that has 128 byte-wide registers. Two jumpers place a block of eight control bytes at one of four I/O bases. That block holds two fixed identifier bytes, a version byte, an LED byte, a page byte, a mode byte and a read-only jumper status byte. When the mode byte enables it, a 32-byte window opens at one of eight I/O bases. The mode byte picks that base from a table whose steps are not even. A host access inside the window becomes a chip select and a 7-bit controller register address. The address is formed from the two-bit page value followed by the low five host address bits, so the host reaches all 128 registers through 32 bus addresses.

The controller's active-low interrupt is routed to one of three host IRQ lines: IRQ5, IRQ6 or IRQ7. Two jumpers pick the line. Each line is modelled as a value plus an output enable, so the board-level tri-state buffer is explicit. When the mode byte asks for sharing and IRQ6 or IRQ7 is selected, the line switches to a drive-low-or-release style.

Host cycles are synchronous to `clk`. Register writes land on the rising clock edge while the write strobe is low. Read data, the chip select and the translated address are combinational from the bus inputs.

Top module: `can_window_glue`

## Requirements
- R1: The control block claims the eight addresses starting at 0x150 + 8*J1 + 16*J2. Here J1 is `jumper_on[0]` and J2 is `jumper_on[1]`, with 1 meaning installed. The full 10-bit address is compared.
- R2: Reads at control offsets 0, 1 and 2 return 0xF6, 0xB9 and the parameter `VERSION`. Writes to these offsets change nothing.
- R3: Offset 3 is a read/write byte. Its low `LED_W` bits drive `led`. `led` changes only on a clock edge where the block claims a write to offset 3.
- R4: Offset 4 is the page byte. Bits 1:0 are writable and bits 7:2 read as zero. A write to it is ignored while mode bit 6 is clear.
- R5: Offset 5 is the mode byte. Bits 6 (window enable), 5 (IRQ sharing) and 2:0 (window select) are writable. Bits 7, 4 and 3 read as zero.
- R6: With mode bit 6 set, the window spans 32 addresses from a base. For select values 0 to 7 the base is 0x100, 0x120, 0x180, 0x1A0, 0x200, 0x240, 0x280 or 0x320. With mode bit 6 clear, no window address is claimed.
- R7: During a window access, `can_cs_n` is low while either host strobe is low. `can_addr` then equals page*32 + (address - base). A window read returns `can_rdata` on the host bus.
- R8: Offset 6 reads {2'b00, jumper_on[4:0], 1'b0}, so bit n shows jumper n.
- R9: Offset 7 reads zero. `io_rdata_oe` is high only during a read that the block claims; otherwise `io_rdata` is zero. No address is claimed while `io_aen` is high.
- R10: The IRQ line is chosen by J4 (`jumper_on[3]`) and J5 (`jumper_on[4]`). Both off selects no line. Both on selects IRQ5, which is index 0 of `irq_oe`/`irq_val`. J4 alone selects IRQ6, index 1. J5 alone selects IRQ7, index 2. Unselected lines have their enable low.
- R11: Without sharing, the selected line is driven with the value NOT `can_irq_n`. Sharing applies only when IRQ6 or IRQ7 is selected. With sharing on, the line is driven low while `can_irq_n` is high and released while it is low.
- R12: After reset, the LED, page and mode bytes are zero, so the window is closed and sharing is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 10 | Host I/O address |
| io_aen | input | 1 | Address enable; high marks a DMA cycle that must be ignored |
| io_rd_n | input | 1 | Host read strobe, active low |
| io_wr_n | input | 1 | Host write strobe, active low |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data |
| io_rdata_oe | output | 1 | Host data bus driver enable |
| jumper_on | input | 5 | Jumpers J1..J5 on bits 0..4, 1 = installed |
| can_irq_n | input | 1 | Controller interrupt, active low |
| can_rdata | input | 8 | Controller read data |
| can_cs_n | output | 1 | Controller chip select, active low |
| can_addr | output | 7 | Translated controller register address |
| led | output | LED_W | LED drive from the low bits of offset 3 |
| irq_val | output | 3 | Drive value for IRQ5, IRQ6, IRQ7 |
| irq_oe | output | 3 | Drive enable for IRQ5, IRQ6, IRQ7 |

## Verification
The hardest case is the link between the mode byte and the page byte. A page write only counts once the window is enabled, and the window base then moves with every change of the select field. The bench first tries a page write while the window is closed and reads the page back as zero. It then enables the window, sets the page, and walks a table of reads at both window edges, the byte just past the window and a DMA-marked cycle. Finally it steps the select field through all eight values and probes each base, each last address and the byte after it. Sharing is reached by combining the sharing bit with jumper patterns for each IRQ line, IRQ5 included, where sharing must be refused.

// File: rtl/can_glue_pkg.sv
package can_glue_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 10;
  localparam int PAGE_W  = 2;
  localparam int WOFF_W  = 5;
  localparam int CADDR_W = PAGE_W + WOFF_W;
  localparam int NIRQ    = 3;

  typedef enum logic [2:0] {
    OFF_ID0  = 3'd0,
    OFF_ID1  = 3'd1,
    OFF_VER  = 3'd2,
    OFF_LED  = 3'd3,
    OFF_PAGE = 3'd4,
    OFF_MODE = 3'd5,
    OFF_JMP  = 3'd6,
    OFF_RSV  = 3'd7
  } ctl_off_e;

  localparam logic [DATA_W-1:0] ID_BYTE0  = 8'hF6;
  localparam logic [DATA_W-1:0] ID_BYTE1  = 8'hB9;
  localparam logic [DATA_W-1:0] MODE_MASK = 8'h67;
  localparam int MODE_WEN   = 6;
  localparam int MODE_SHARE = 5;

  localparam logic [ADDR_W-4:0] CTL_BASE_HI = 7'h2A;

  function automatic logic [ADDR_W-1:0] win_base(input logic [2:0] sel);
    case (sel)
      3'd0: win_base = 10'h100;
      3'd1: win_base = 10'h120;
      3'd2: win_base = 10'h180;
      3'd3: win_base = 10'h1A0;
      3'd4: win_base = 10'h200;
      3'd5: win_base = 10'h240;
      3'd6: win_base = 10'h280;
      default: win_base = 10'h320;
    endcase
  endfunction
endpackage

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
  import can_glue_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  input  logic [1:0]        base_jmp,
  input  logic              win_en,
  input  logic [2:0]        win_sel,
  output logic              ctl_hit,
  output ctl_off_e          ctl_off,
  output logic              win_hit
);
  logic [ADDR_W-4:0]        ctl_hi;
  logic [ADDR_W-1:0]        wbase;

  always_comb begin
    ctl_hi  = CTL_BASE_HI + {5'd0, base_jmp[1], base_jmp[0]};
    wbase   = win_base(win_sel);
    ctl_hit = !aen && (addr[ADDR_W-1:3] == ctl_hi);
    ctl_off = ctl_off_e'(addr[2:0]);
    win_hit = !aen && win_en &&
              (addr[ADDR_W-1:WOFF_W] == wbase[ADDR_W-1:WOFF_W]);
  end
endmodule

// File: rtl/glue_regs.sv
module glue_regs
  import can_glue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  ctl_off_e          wr_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] led_q,
  output logic [PAGE_W-1:0] page_q,
  output logic [DATA_W-1:0] mode_q
);
  logic [DATA_W-1:0] led_d, mode_d;
  logic [PAGE_W-1:0] page_d;
  logic              led_ce, page_ce, mode_ce;

  always_comb begin
    led_ce  = wr_en && (wr_off == OFF_LED);
    mode_ce = wr_en && (wr_off == OFF_MODE);
    page_ce = wr_en && (wr_off == OFF_PAGE) && mode_q[MODE_WEN];
    led_d   = wdata;
    mode_d  = wdata & MODE_MASK;
    page_d  = wdata[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      page_q <= '0;
      mode_q <= '0;
    end else begin
      if (led_ce)  led_q  <= led_d;
      if (page_ce) page_q <= page_d;
      if (mode_ce) mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/glue_irq_route.sv
module glue_irq_route
  import can_glue_pkg::*;
(
  input  logic            j4,
  input  logic            j5,
  input  logic            share_req,
  input  logic            can_irq_n,
  output logic [NIRQ-1:0] irq_val,
  output logic [NIRQ-1:0] irq_oe
);
  logic [NIRQ-1:0] sel;
  logic            share_ok;

  always_comb begin
    sel[0]   = j4 && j5;
    sel[1]   = j4 && !j5;
    sel[2]   = !j4 && j5;
    share_ok = share_req && (sel[1] || sel[2]);
  end

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    always_comb begin
      irq_oe[g]  = sel[g] && (share_ok ? can_irq_n : 1'b1);
      irq_val[g] = sel[g] && !share_ok && !can_irq_n;
    end
  end
endmodule

// File: rtl/can_window_glue.sv
module can_window_glue
  import can_glue_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h01,
  parameter int         LED_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        io_addr,
  input  logic              io_aen,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rdata_oe,
  input  logic [4:0]        jumper_on,
  input  logic              can_irq_n,
  input  logic [7:0]        can_rdata,
  output logic              can_cs_n,
  output logic [6:0]        can_addr,
  output logic [LED_W-1:0]  led,
  output logic [2:0]        irq_val,
  output logic [2:0]        irq_oe
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              ctl_hit, win_hit;
  ctl_off_e          ctl_off;
  logic [DATA_W-1:0] led_q, mode_q, ctl_rdata;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  glue_addr_decode i_dec (
    .addr     (io_addr),
    .aen      (io_aen),
    .base_jmp (jumper_on[1:0]),
    .win_en   (mode_q[MODE_WEN]),
    .win_sel  (mode_q[2:0]),
    .ctl_hit  (ctl_hit),
    .ctl_off  (ctl_off),
    .win_hit  (win_hit)
  );

  glue_regs i_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (ctl_hit && !io_wr_n),
    .wr_off (ctl_off),
    .wdata  (io_wdata),
    .led_q  (led_q),
    .page_q (page_q),
    .mode_q (mode_q)
  );

  glue_irq_route i_irq (
    .j4        (jumper_on[3]),
    .j5        (jumper_on[4]),
    .share_req (mode_q[MODE_SHARE]),
    .can_irq_n (can_irq_n),
    .irq_val   (irq_val),
    .irq_oe    (irq_oe)
  );

  always_comb begin
    case (ctl_off)
      OFF_ID0:  ctl_rdata = ID_BYTE0;
      OFF_ID1:  ctl_rdata = ID_BYTE1;
      OFF_VER:  ctl_rdata = VERSION;
      OFF_LED:  ctl_rdata = led_q;
      OFF_PAGE: ctl_rdata = {{(DATA_W-PAGE_W){1'b0}}, page_q};
      OFF_MODE: ctl_rdata = mode_q;
      OFF_JMP:  ctl_rdata = {2'b00, jumper_on, 1'b0};
      default:  ctl_rdata = '0;
    endcase
  end

  always_comb begin
    io_rdata_oe = !io_rd_n && (ctl_hit || win_hit);
    if (!io_rdata_oe)  io_rdata = '0;
    else if (win_hit)  io_rdata = can_rdata;
    else               io_rdata = ctl_rdata;
    can_cs_n = !(win_hit && (!io_rd_n || !io_wr_n));
    can_addr = {page_q, io_addr[WOFF_W-1:0]};
    led      = led_q[LED_W-1:0];
  end
endmodule

// File: rtl/glue_checker.sv
module glue_checker #(
  parameter int LED_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [9:0]       io_addr,
  input logic             io_aen,
  input logic             io_rd_n,
  input logic             io_wr_n,
  input logic             io_rdata_oe,
  input logic             can_cs_n,
  input logic [6:0]       can_addr,
  input logic [LED_W-1:0] led,
  input logic [2:0]       irq_oe
);
  assert_rdata_only_on_read_R9: assert property (@(posedge clk)
    disable iff (!rst_n) io_rdata_oe |-> (!io_rd_n && !io_aen));

  assert_cs_offset_R7: assert property (@(posedge clk)
    disable iff (!rst_n) !can_cs_n |->
      (can_addr[4:0] == io_addr[4:0] && !io_aen && (!io_rd_n || !io_wr_n)));

  assert_one_irq_line_R10: assert property (@(posedge clk)
    disable iff (!rst_n) $onehot0(irq_oe));

  assert_led_hold_R3: assert property (@(posedge clk)
    disable iff (!rst_n) io_wr_n |=> $stable(led));

  assert_no_drive_on_write_R9: assert property (@(posedge clk)
    disable iff (!rst_n) (!io_wr_n && io_rd_n) |-> !io_rdata_oe);
endmodule

bind can_window_glue glue_checker #(.LED_W(LED_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_addr     (io_addr),
  .io_aen      (io_aen),
  .io_rd_n     (io_rd_n),
  .io_wr_n     (io_wr_n),
  .io_rdata_oe (io_rdata_oe),
  .can_cs_n    (can_cs_n),
  .can_addr    (can_addr),
  .led         (led),
  .irq_oe      (irq_oe)
);

// File: tb/test_can_window_glue.sv
`timescale 1ns/1ps
module test_can_window_glue;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] io_addr;
  logic       io_aen, io_rd_n, io_wr_n;
  logic [7:0] io_wdata, io_rdata, can_rdata;
  logic       io_rdata_oe, can_irq_n, can_cs_n;
  logic [4:0] jumper_on;
  logic [6:0] can_addr;
  logic [1:0] led;
  logic [2:0] irq_val, irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_window_glue #(.VERSION(8'h01), .LED_W(2)) i_can_window_glue (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_aen(io_aen),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe), .jumper_on(jumper_on),
    .can_irq_n(can_irq_n), .can_rdata(can_rdata), .can_cs_n(can_cs_n),
    .can_addr(can_addr), .led(led), .irq_val(irq_val), .irq_oe(irq_oe)
  );

  // vector: addr(10) aen(1) exp_oe(1) exp_data(8) exp_cs_n(1) exp_caddr(7)
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {10'h158, 1'b0, 1'b1, 8'hF6, 1'b1, 7'h00},  // R2
    {10'h159, 1'b0, 1'b1, 8'hB9, 1'b1, 7'h00},  // R2
    {10'h15A, 1'b0, 1'b1, 8'h01, 1'b1, 7'h00},  // R2
    {10'h15B, 1'b0, 1'b1, 8'hA5, 1'b1, 7'h00},  // R3
    {10'h15C, 1'b0, 1'b1, 8'h03, 1'b1, 7'h00},  // R4
    {10'h15D, 1'b0, 1'b1, 8'h67, 1'b1, 7'h00},  // R5
    {10'h15E, 1'b0, 1'b1, 8'h2A, 1'b1, 7'h00},  // R8
    {10'h15F, 1'b0, 1'b1, 8'h00, 1'b1, 7'h00},  // R9
    {10'h150, 1'b0, 1'b0, 8'h00, 1'b1, 7'h00},  // R1
    {10'h320, 1'b0, 1'b1, 8'h3C, 1'b0, 7'h60},  // R7
    {10'h33F, 1'b0, 1'b1, 8'h3C, 1'b0, 7'h7F},  // R7
    {10'h31F, 1'b0, 1'b0, 8'h00, 1'b1, 7'h00},  // R6
    {10'h340, 1'b0, 1'b0, 8'h00, 1'b1, 7'h00},  // R6
    {10'h158, 1'b1, 1'b0, 8'h00, 1'b1, 7'h00}   // R9
  };

  localparam logic [9:0] BASES [8] = '{
    10'h100, 10'h120, 10'h180, 10'h1A0, 10'h200, 10'h240, 10'h280, 10'h320};

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr_n = 1'b0;
    @(negedge clk);
    io_wr_n = 1'b1;
  endtask

  logic       r_oe, r_cs_n;
  logic [7:0] r_data;
  logic [6:0] r_caddr;

  task automatic bus_rd(input logic [9:0] a, input logic aen);
    @(negedge clk);
    io_addr = a; io_aen = aen; io_rd_n = 1'b0;
    #2;
    r_oe = io_rdata_oe; r_data = io_rdata; r_cs_n = can_cs_n;
    r_caddr = can_addr;
    #2;
    io_rd_n = 1'b1; io_aen = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_aen = 1'b0; io_rd_n = 1'b1;
    io_wr_n = 1'b1; io_wdata = '0; can_rdata = 8'h3C; can_irq_n = 1'b1;
    jumper_on = 5'b10101;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R12 reset state
    bus_rd(10'h15D, 1'b0); chk("R12 mode", r_data, 8'h00);
    bus_rd(10'h15B, 1'b0); chk("R12 led byte", r_data, 8'h00);
    chk("R12 led pins", led, 2'b00);
    chk("R10 IRQ7 oe", irq_oe, 3'b100);
    chk("R11 IRQ7 idle val", irq_val, 3'b000);

    // R4 page write ignored while window closed
    bus_wr(10'h15C, 8'h03);
    bus_rd(10'h15C, 1'b0); chk("R4 page locked", r_data, 8'h00);
    // R6 window closed
    bus_rd(10'h105, 1'b0);
    chk("R6 closed oe", r_oe, 1'b0); chk("R6 closed cs", r_cs_n, 1'b1);

    bus_wr(10'h15D, 8'hFF);
    bus_wr(10'h15C, 8'hFF);
    bus_wr(10'h15B, 8'hA5);
    chk("R3 led pins", led, 2'b01);

    for (int i = 0; i < NV; i++) begin
      bus_rd(VEC[i][27:18], VEC[i][17]);
      chk($sformatf("R9 vec%0d oe", i), r_oe, VEC[i][16]);
      chk($sformatf("R2 vec%0d data", i), r_data, VEC[i][15:8]);
      chk($sformatf("R7 vec%0d cs", i), r_cs_n, VEC[i][7]);
      if (!VEC[i][7]) chk($sformatf("R7 vec%0d addr", i), r_caddr, VEC[i][6:0]);
    end

    // R7 window write: chip select, no host drive
    @(negedge clk);
    io_addr = 10'h325; io_wr_n = 1'b0; #2;
    chk("R7 wr cs", can_cs_n, 1'b0); chk("R7 wr addr", can_addr, 7'h65);
    chk("R9 wr no drive", io_rdata_oe, 1'b0);
    @(negedge clk); io_wr_n = 1'b1;

    // R2 writes to fixed bytes ignored
    bus_wr(10'h158, 8'h00);
    bus_rd(10'h158, 1'b0); chk("R2 id after write", r_data, 8'hF6);

    // R11 sharing on IRQ7
    #1; chk("R11 shared idle oe", irq_oe, 3'b100);
    chk("R11 shared idle val", irq_val, 3'b000);
    can_irq_n = 1'b0; #1;
    chk("R11 shared active released", irq_oe, 3'b000);
    bus_wr(10'h15D, 8'h46);
    #1; chk("R11 active drive oe", irq_oe, 3'b100);
    chk("R11 active drive val", irq_val, 3'b100);

    // R10/R11 IRQ5 refuses sharing
    bus_wr(10'h15D, 8'h60);
    jumper_on = 5'b11101; #1;
    chk("R11 IRQ5 no share oe", irq_oe, 3'b001);
    chk("R11 IRQ5 val", irq_val, 3'b001);
    jumper_on = 5'b01101; #1;
    chk("R10 IRQ6 shared released", irq_oe, 3'b000);
    can_irq_n = 1'b1; #1;
    chk("R10 IRQ6 shared idle", irq_oe, 3'b010);
    jumper_on = 5'b00101; #1;
    chk("R10 none", irq_oe, 3'b000);

    // R1 base selection
    jumper_on = 5'b00010;
    bus_rd(10'h160, 1'b0); chk("R1 base 160", r_data, 8'hF6);
    bus_rd(10'h158, 1'b0); chk("R1 158 unclaimed", r_oe, 1'b0);
    jumper_on = 5'b00011;
    bus_rd(10'h169, 1'b0); chk("R1 base 168", r_data, 8'hB9);
    jumper_on = 5'b00000;
    bus_rd(10'h150, 1'b0); chk("R1 base 150", r_data, 8'hF6);

    // R6 all window bases
    for (int s = 0; s < 8; s++) begin
      bus_wr(10'h155, 8'h40 | 8'(s));
      bus_rd(BASES[s], 1'b0);
      chk($sformatf("R6 sel%0d base", s), r_oe, 1'b1);
      chk($sformatf("R7 sel%0d addr", s), r_caddr, 7'h60);
      bus_rd(BASES[s] + 10'h1F, 1'b0);
      chk($sformatf("R6 sel%0d last", s), r_oe, 1'b1);
      bus_rd(BASES[s] + 10'h20, 1'b0);
      chk($sformatf("R6 sel%0d past", s), r_oe, 1'b0);
    end

    // R12 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    bus_rd(10'h154, 1'b0); chk("R12 page after reset", r_data, 8'h00);
    bus_rd(10'h155, 1'b0); chk("R12 mode after reset", r_data, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule